// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Event and Alarm Unit

This unit gathers five real-time-clock event sources into a latched flag register and raises one interrupt line. The sources are calibration start, calibration finish, a compare hit, the one-second tick and an alarm. Calibration and compare strobes arrive from neighbouring logic. The alarm is generated inside the unit by comparing the running BCD time and date words against two programmed alarm registers.

Software reaches the unit through a single-cycle register port. A write takes effect on the clock edge where `reg_we` is high. Reads are combinational on `reg_addr`. Software clears a flag by writing a 1 to its bit. It selects which flags reach the interrupt line through an enable register. A status register lets a time-reading routine see whether a second boundary passed during its read, whatever the enable setting. A command bit in the flag register emits a one-cycle update request to the time-keeping logic.

Top module: `rtc_event_irq`

## Requirements
- R1: Flag bit positions are fixed. Bit 0 is calibration start, bit 1 is calibration finish, bit 2 is compare, bit 3 is the one-second tick and bit 4 is the alarm. A high input strobe sets its bit at the next clock edge, and the bit stays set until software clears it.
- R2: Writing the flag register (address 0) with a 1 in bits 4:0 clears those flags. A 0 in a bit leaves that flag unchanged.
- R3: The enable register (address 1) uses the same bit map as the flag register. `irq` is high exactly when some flag is set and its enable bit is 1.
- R4: The status register (address 2) reads, in bits 4:0, each flag ANDed with its enable. The exception is bit 3, which shows the raw one-second flag regardless of its enable.
- R5: The alarm time (address 3, 21 bits) and alarm date (address 4, 19 bits) are both compared. An alarm requires the time word and the date word to equal their registers together.
- R6: The alarm flag is set only in the cycle in which the match first becomes true. Clearing the flag while the match still holds leaves it clear. A later fresh match sets it again.
- R7: Writing a 1 to bit 31 of the flag register drives `upd_req` high for exactly one cycle after the write. Bit 31 always reads as 0, and a write with only bit 31 set clears no flag.
- R8: If a strobe sets a flag in the same cycle that a clear write targets that flag, the set wins and the flag stays 1. Other bits in the same write are still cleared.
- R9: After reset, all flags, enables and alarm registers read 0, and `irq` and `upd_req` are low.
- R10: A cleared flag reads 0 in the first cycle after the clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_time | input | 21 | Running BCD time word |
| cur_date | input | 19 | Running BCD date word |
| sec_tick | input | 1 | One-second strobe |
| cal_start | input | 1 | Calibration start strobe |
| cal_done | input | 1 | Calibration finish strobe |
| cmp_hit | input | 1 | Compare strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt |
| upd_req | output | 1 | One-cycle time update request |

## Verification
Two functions can land on the same edge: a source strobe setting a flag and a software write-one clearing that same flag. The bench drives both in one cycle. It does this for the one-second tick, and again for a calibration-finish strobe paired with a clear of calibration start. A behavioural model predicts the outcome: set wins for the shared bit, and the clear still applies to the other bit. The model is compared against `irq`, `upd_req` and the addressed read word on every clock.

// File: rtl/rtc_event_irq.sv
module rtc_event_irq #(
  parameter int TIME_W  = 21,
  parameter int DATE_W  = 19,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int UPD_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] cur_time,
  input  logic [DATE_W-1:0] cur_date,
  input  logic              sec_tick,
  input  logic              cal_start,
  input  logic              cal_done,
  input  logic              cmp_hit,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              upd_req
);
  localparam int NSRC = 5;
  localparam int SEC_BIT = 3;
  localparam logic [ADDR_W-1:0] A_EVT   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ATIME = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ADATE = ADDR_W'(4);
  localparam logic [NSRC-1:0] SEC_MASK = NSRC'(1) << SEC_BIT;

  logic [NSRC-1:0]   flag, en, src, clr, stat;
  logic [TIME_W-1:0] atime;
  logic [DATE_W-1:0] adate;
  logic              match, match_q, alarm_hit, evt_we;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata;

  assign match     = (cur_time == atime) && (cur_date == adate);
  assign alarm_hit = match && !match_q;
  assign src       = {alarm_hit, sec_tick, cmp_hit, cal_done, cal_start};
  assign evt_we    = reg_we && (reg_addr == A_EVT);
  assign clr       = evt_we ? reg_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= '0;
      en      <= '0;
      atime   <= '0;
      adate   <= '0;
      match_q <= 1'b0;
      upd_req <= 1'b0;
    end else begin
      flag    <= (flag & ~clr) | src;
      match_q <= match;
      upd_req <= evt_we && reg_wdata[UPD_BIT];
      if (reg_we && reg_addr == A_EN)    en    <= reg_wdata[NSRC-1:0];
      if (reg_we && reg_addr == A_ATIME) atime <= reg_wdata[TIME_W-1:0];
      if (reg_we && reg_addr == A_ADATE) adate <= reg_wdata[DATE_W-1:0];
    end
  end

  assign irq  = |(flag & en);
  assign stat = (flag & en) | (flag & SEC_MASK);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EVT:   reg_rdata = {{(DATA_W-NSRC){1'b0}}, flag};
      A_EN:    reg_rdata = {{(DATA_W-NSRC){1'b0}}, en};
      A_STAT:  reg_rdata = {{(DATA_W-NSRC){1'b0}}, stat};
      A_ATIME: reg_rdata = {{(DATA_W-TIME_W){1'b0}}, atime};
      A_ADATE: reg_rdata = {{(DATA_W-DATE_W){1'b0}}, adate};
      default: reg_rdata = '0;
    endcase
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src) |=> ((flag & $past(src)) == $past(src))); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_we |=> ((flag & $past(clr & ~src)) == '0)); // R2
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|src) || $past(reg_we && reg_addr == A_EN))); // R3
  AST_UPD_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |-> $past(evt_we && reg_wdata[UPD_BIT])); // R7
  AST_ALARM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> !alarm_hit); // R6
endmodule

// File: tb/rtc_event_irq_tb.sv
`timescale 1ns/1ps
module rtc_event_irq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [20:0] cur_time = 21'h0A5A5;
  logic [18:0] cur_date = 19'h01111;
  logic sec_tick = 0, cal_start = 0, cal_done = 0, cmp_hit = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic irq, upd_req;

  int n_chk = 0, n_fail = 0;
  logic [4:0] m_flag = 0, m_en = 0;
  logic [20:0] m_at = 0;
  logic [18:0] m_ad = 0;
  logic m_mp = 0, m_upd = 0;

  always #2 clk = ~clk;

  rtc_event_irq u_dut (.clk(clk), .rst_n(rst_n), .cur_time(cur_time), .cur_date(cur_date),
    .sec_tick(sec_tick), .cal_start(cal_start), .cal_done(cal_done), .cmp_hit(cmp_hit),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .upd_req(upd_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: exp_rd = {27'd0, m_flag};
      3'd1: exp_rd = {27'd0, m_en};
      3'd2: exp_rd = {27'd0, (m_flag & m_en) | (m_flag & 5'b01000)};
      3'd3: exp_rd = {11'd0, m_at};
      3'd4: exp_rd = {13'd0, m_ad};
      default: exp_rd = 0;
    endcase
  endfunction

  task automatic tick();
    logic mt;
    logic [4:0] s, c, nf, ne;
    logic [20:0] nat;
    logic [18:0] nad;
    logic nu;
    mt = (cur_time == m_at) && (cur_date == m_ad);
    s = {mt && !m_mp, sec_tick, cmp_hit, cal_done, cal_start};
    c = (reg_we && reg_addr == 0) ? reg_wdata[4:0] : 5'd0;
    nf = (m_flag & ~c) | s;
    ne = (reg_we && reg_addr == 1) ? reg_wdata[4:0] : m_en;
    nat = (reg_we && reg_addr == 3) ? reg_wdata[20:0] : m_at;
    nad = (reg_we && reg_addr == 4) ? reg_wdata[18:0] : m_ad;
    nu = reg_we && reg_addr == 0 && reg_wdata[31];
    @(posedge clk);
    m_flag = nf; m_en = ne; m_at = nat; m_ad = nad; m_mp = mt; m_upd = nu;
    @(negedge clk);
    chk("R3 irq", {31'd0, irq}, {31'd0, |(m_flag & m_en)});
    chk("R7 upd_req", {31'd0, upd_req}, {31'd0, m_upd});
    chk("R2 read", reg_rdata, exp_rd(reg_addr));
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    reg_addr = 0;
  endtask

  task automatic pulse(input int i);
    cal_start = (i == 0); cal_done = (i == 1); cmp_hit = (i == 2); sec_tick = (i == 3);
    tick();
    cal_start = 0; cal_done = 0; cmp_hit = 0; sec_tick = 0;
  endtask

  initial begin
    #80000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R9 irq", {31'd0, irq}, 0);
    chk("R9 upd_req", {31'd0, upd_req}, 0);
    rst_n = 1;
    rd(0, 0, "R9 flags"); rd(1, 0, "R9 enable"); rd(2, 0, "R9 status");
    rd(3, 0, "R9 alarm time"); rd(4, 0, "R9 alarm date");

    for (int i = 0; i < 4; i++) begin
      pulse(i);
      rd(0, 32'(1) << i, "R1 bit map");
      chk("R3 masked", {31'd0, irq}, 0);
      wr(0, 0);
      rd(0, 32'(1) << i, "R2 zero keeps");
      wr(0, 32'(1) << i);
      rd(0, 0, "R10 cleared next cycle");
    end

    wr(1, 32'h0A);
    pulse(0);
    chk("R3 disabled source", {31'd0, irq}, 0);
    rd(2, 0, "R4 masked status");
    pulse(3);
    chk("R3 enabled source", {31'd0, irq}, 1);
    rd(2, 32'h08, "R4 status");
    wr(1, 0);
    chk("R3 enable off", {31'd0, irq}, 0);
    rd(2, 32'h08, "R4 raw second");
    rd(0, 32'h09, "R1 flags kept");
    wr(0, 32'h1F);

    wr(1, 32'h10);
    wr(3, 32'h12345);
    wr(4, 32'h2A5C3);
    rd(3, 32'h12345, "R5 alarm time rb");
    cur_time = 21'h12345; cur_date = 19'h2A5C2;
    tick(); tick();
    rd(0, 0, "R5 date mismatch");
    cur_time = 21'h12346; cur_date = 19'h2A5C3;
    tick(); tick();
    rd(0, 0, "R5 time mismatch");
    cur_time = 21'h12345;
    tick();
    rd(0, 32'h10, "R5 full match");
    chk("R5 alarm irq", {31'd0, irq}, 1);
    wr(0, 32'h10);
    tick(); tick(); tick();
    rd(0, 0, "R6 no refire while held");
    cur_time = 21'h12346; tick();
    cur_time = 21'h12345; tick();
    rd(0, 32'h10, "R6 fresh match");
    wr(0, 32'h10);
    cur_time = 21'h00100; tick();

    pulse(2);
    wr(0, 32'h8000_0000);
    chk("R7 pulse high", {31'd0, upd_req}, 1);
    rd(0, 32'h04, "R7 no clear, bit31 reads 0");
    tick();
    chk("R7 pulse ends", {31'd0, upd_req}, 0);
    wr(0, 32'h04);

    sec_tick = 1; wr(0, 32'h08); sec_tick = 0;
    rd(0, 32'h08, "R8 set wins");
    wr(0, 32'h08);
    pulse(0);
    cal_done = 1; wr(0, 32'h01); cal_done = 0;
    rd(0, 32'h02, "R8 other bit cleared");
    wr(0, 32'h1F);
    rd(0, 0, "R10 all cleared");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule